// File: doc/BRIEF.md
# Single-Cycle 32-bit Integer Core

This block is a small 32-bit processor core in which every instruction starts and finishes between two consecutive rising clock edges. It holds a program counter, a bank of 32 general registers whose entry 0 is fixed at zero, an arithmetic/logic unit, an immediate widener and purely combinational control. Each cycle it presents the program counter to an instruction port, decodes the returned word, reads two registers, computes a result and, on the next rising edge, commits the register write, the memory write and the new program counter together.

The supported operations are register-register add, subtract, bitwise AND and bitwise OR, an OR with a 16-bit immediate, a word load, a word store and a branch on equality. Neither branches nor loads have delay slots: the instruction after a taken branch is the branch target, and the instruction after a load already sees the loaded word. Any other opcode or function code leaves registers and memory untouched and simply moves on to the next word. Both memories sit outside the core; reads from each are combinational and data memory captures a write on the rising edge while the write strobe is high.

Top module: `onecyc_core`

## Requirements
- R1: While `rst_n` is low the core drives `imem_addr` equal to `RESET_PC` (default 0) and keeps `dmem_we` low; all registers hold zero when reset is released.
- R2: In straight-line code `imem_addr` increases by 4 on every rising edge.
- R3: Opcode 0x00 (bits 31:26) with function code 0x20, 0x22, 0x24 or 0x25 (bits 5:0) writes rs+rt, rs-rt, rs&rt or rs|rt into register rd (bits 15:11), with rs in bits 25:21 and rt in bits 20:16; the word 0x012A4020 adds registers 9 and 10 into register 8.
- R4: Opcode 0x0D ORs rs with the zero-extended 16-bit immediate (bits 15:0) and writes register rt, so 0x8000 contributes 0x00008000.
- R5: Opcode 0x23 reads the word at rs plus the sign-extended immediate into register rt, and the very next instruction sees the loaded value.
- R6: Opcode 0x2B drives `dmem_addr` with rs plus the sign-extended immediate, `dmem_wdata` with register rt, and raises `dmem_we`; no other instruction raises `dmem_we`.
- R7: Opcode 0x04 compares rs with rt; when equal the next address is PC+4 plus the sign-extended immediate shifted left by two, otherwise PC+4, with no delay slot.
- R8: Register 0 always reads as zero and writes aimed at it are discarded.
- R9: An unknown opcode, or opcode 0x00 with an unknown function code, writes neither a register nor memory, and the PC advances by 4.
- R10: Load, store and branch immediates are sign-extended, so negative offsets (such as 0xFFFC) address below the base and branch backwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock; all state changes here |
| rst_n | input | 1 | Synchronous active-low reset |
| imem_addr | output | 32 | Byte address of the instruction being executed (the PC) |
| imem_data | input | 32 | Instruction word at `imem_addr`, combinational |
| dmem_addr | output | 32 | Byte address for a load or store |
| dmem_wdata | output | 32 | Word to store |
| dmem_we | output | 1 | Store strobe, captured by memory on the rising edge |
| dmem_rdata | input | 32 | Word at `dmem_addr`, combinational |

## Verification
On every cycle the embedded assertions check the program-counter step for both branch outcomes, that register 0 reads zero on both read ports, that an undefined encoding raises no write strobe, that only the store opcode drives the memory strobe, and the extension mode of the immediate for the logical and memory operations. Arithmetic results, the absence of a load delay, the loop taken backward through a negative offset, and the fact that discarded writes really left register contents unchanged can only be shown by the bench, which runs a program against a behavioural instruction model cycle by cycle and exposes register contents through stores.

// File: rtl/onecyc_pkg.sv
package onecyc_pkg;

  localparam int WORD_W = 32;
  localparam int IMM_W  = 16;
  localparam int OPC_W  = 6;
  localparam int FN_W   = 6;

  typedef logic [OPC_W-1:0] opc_t;
  typedef logic [FN_W-1:0]  fn_t;

  localparam opc_t OPC_RTYPE = 6'h00;
  localparam opc_t OPC_ORI   = 6'h0D;
  localparam opc_t OPC_LW    = 6'h23;
  localparam opc_t OPC_SW    = 6'h2B;
  localparam opc_t OPC_BEQ   = 6'h04;

  localparam fn_t FN_ADD = 6'h20;
  localparam fn_t FN_SUB = 6'h22;
  localparam fn_t FN_AND = 6'h24;
  localparam fn_t FN_OR  = 6'h25;

  typedef enum logic [1:0] {
    ALU_ADD = 2'd0,
    ALU_SUB = 2'd1,
    ALU_AND = 2'd2,
    ALU_OR  = 2'd3
  } alu_op_e;

  typedef struct packed {
    logic    rf_we;       // write the register file
    logic    dst_is_rd;   // destination taken from rd instead of rt
    logic    src_imm;     // ALU operand B is the widened immediate
    logic    ext_signed;  // sign-extend the immediate
    alu_op_e alu_op;
    logic    mem_we;      // store
    logic    mem_to_reg;  // load result selects memory data
    logic    branch;      // equality branch
    logic    illegal;     // encoding not recognised
  } ctrl_t;

  function automatic logic [WORD_W-1:0] widen_imm(input logic [IMM_W-1:0] imm,
                                                   input logic            sgn);
    if (sgn) return {{(WORD_W-IMM_W){imm[IMM_W-1]}}, imm};
    return {{(WORD_W-IMM_W){1'b0}}, imm};
  endfunction

  function automatic logic [WORD_W-1:0] alu_eval(input alu_op_e           op,
                                                 input logic [WORD_W-1:0] a,
                                                 input logic [WORD_W-1:0] b);
    case (op)
      ALU_ADD: return a + b;
      ALU_SUB: return a - b;
      ALU_AND: return a & b;
      default: return a | b;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] branch_dest(input logic [WORD_W-1:0] seq_pc,
                                                    input logic [WORD_W-1:0] word_off);
    return seq_pc + {word_off[WORD_W-3:0], 2'b00};
  endfunction

endpackage

// File: rtl/onecyc_decode.sv
module onecyc_decode
  import onecyc_pkg::*;
(
  input  opc_t  opcode,
  input  fn_t   funct,
  output ctrl_t ctl
);

  always_comb begin
    ctl = '0;
    case (opcode)
      OPC_RTYPE: begin
        ctl.dst_is_rd = 1'b1;
        case (funct)
          FN_ADD: begin ctl.rf_we = 1'b1; ctl.alu_op = ALU_ADD; end
          FN_SUB: begin ctl.rf_we = 1'b1; ctl.alu_op = ALU_SUB; end
          FN_AND: begin ctl.rf_we = 1'b1; ctl.alu_op = ALU_AND; end
          FN_OR:  begin ctl.rf_we = 1'b1; ctl.alu_op = ALU_OR;  end
          default: ctl.illegal = 1'b1;
        endcase
      end
      OPC_ORI: begin
        ctl.rf_we   = 1'b1;
        ctl.src_imm = 1'b1;
        ctl.alu_op  = ALU_OR;
      end
      OPC_LW: begin
        ctl.rf_we      = 1'b1;
        ctl.src_imm    = 1'b1;
        ctl.ext_signed = 1'b1;
        ctl.alu_op     = ALU_ADD;
        ctl.mem_to_reg = 1'b1;
      end
      OPC_SW: begin
        ctl.mem_we     = 1'b1;
        ctl.src_imm    = 1'b1;
        ctl.ext_signed = 1'b1;
        ctl.alu_op     = ALU_ADD;
      end
      OPC_BEQ: begin
        ctl.branch     = 1'b1;
        ctl.ext_signed = 1'b1;
        ctl.alu_op     = ALU_SUB;
      end
      default: ctl.illegal = 1'b1;
    endcase
  end

endmodule

// File: rtl/onecyc_alu.sv
module onecyc_alu
  import onecyc_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y,
  output logic         eq
);

  always_comb begin
    y  = alu_eval(op, a, b);
    eq = (a == b);
  end

endmodule

// File: rtl/onecyc_regfile.sv
module onecyc_regfile #(
  parameter int NREGS = 32,
  parameter int W     = 32,
  parameter int NRD   = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NRD-1:0][$clog2(NREGS)-1:0] rd_idx,
  output logic [NRD-1:0][W-1:0]     rd_data,
  input  logic                      wr_en,
  input  logic [$clog2(NREGS)-1:0]  wr_idx,
  input  logic [W-1:0]              wr_data
);

  localparam int IDX_W = $clog2(NREGS);

  logic [W-1:0] cells [NREGS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) cells[i] <= '0;
    end else begin
      for (int i = 1; i < NREGS; i++) begin
        if (wr_en && (wr_idx == IDX_W'(i))) cells[i] <= wr_data;
      end
    end
  end

  genvar p;
  generate
    for (p = 0; p < NRD; p++) begin : g_rd
      assign rd_data[p] = (rd_idx[p] == '0) ? '0 : cells[rd_idx[p]];

      // R8: the zero register reads zero on every port
      assert_zero_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_idx[p] == '0) |-> (rd_data[p] == '0));
    end
  endgenerate

endmodule

// File: rtl/onecyc_core.sv
module onecyc_core
  import onecyc_pkg::*;
#(
  parameter logic [31:0] RESET_PC = 32'h0000_0000,
  parameter int          NREGS    = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic [31:0] imem_addr,
  input  logic [31:0] imem_data,
  output logic [31:0] dmem_addr,
  output logic [31:0] dmem_wdata,
  output logic        dmem_we,
  input  logic [31:0] dmem_rdata
);

  localparam int IDX_W = $clog2(NREGS);

  // program counter
  logic [WORD_W-1:0] pc_q, pc_next, pc_plus4, br_target;
  logic              take_branch;

  // instruction fields
  opc_t              f_op;
  fn_t               f_fn;
  logic [4:0]        f_rs, f_rt, f_rd;
  logic [IMM_W-1:0]  f_imm;

  ctrl_t             ctl;
  logic [WORD_W-1:0] imm_ext, rs_val, rt_val, alu_b, alu_y, wb_data;
  logic              operands_equal;
  logic [1:0][IDX_W-1:0]  rd_idx_w;
  logic [1:0][WORD_W-1:0] rd_data_w;
  logic [IDX_W-1:0]  wb_idx;
  logic              rf_wr_en;

  assign f_op  = imem_data[31:26];
  assign f_rs  = imem_data[25:21];
  assign f_rt  = imem_data[20:16];
  assign f_rd  = imem_data[15:11];
  assign f_fn  = imem_data[5:0];
  assign f_imm = imem_data[15:0];

  onecyc_decode u_dec (
    .opcode (f_op),
    .funct  (f_fn),
    .ctl    (ctl)
  );

  assign rd_idx_w = {f_rt[IDX_W-1:0], f_rs[IDX_W-1:0]};
  assign wb_idx   = ctl.dst_is_rd ? f_rd[IDX_W-1:0] : f_rt[IDX_W-1:0];
  assign rf_wr_en = ctl.rf_we;

  onecyc_regfile #(.NREGS(NREGS), .W(WORD_W), .NRD(2)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_idx  (rd_idx_w),
    .rd_data (rd_data_w),
    .wr_en   (rf_wr_en),
    .wr_idx  (wb_idx),
    .wr_data (wb_data)
  );

  assign rs_val  = rd_data_w[0];
  assign rt_val  = rd_data_w[1];
  assign imm_ext = widen_imm(f_imm, ctl.ext_signed);
  assign alu_b   = ctl.src_imm ? imm_ext : rt_val;

  onecyc_alu #(.W(WORD_W)) u_alu (
    .op (ctl.alu_op),
    .a  (rs_val),
    .b  (alu_b),
    .y  (alu_y),
    .eq (operands_equal)
  );

  assign wb_data    = ctl.mem_to_reg ? dmem_rdata : alu_y;
  assign dmem_addr  = alu_y;
  assign dmem_wdata = rt_val;
  assign dmem_we    = ctl.mem_we & rst_n;

  assign pc_plus4    = pc_q + 32'd4;
  assign br_target   = branch_dest(pc_plus4, imm_ext);
  assign take_branch = ctl.branch & operands_equal;
  assign pc_next     = take_branch ? br_target : pc_plus4;
  assign imem_addr   = pc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) pc_q <= RESET_PC;
    else        pc_q <= pc_next;
  end

  // R2: sequential step when no branch is taken
  assert_pc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !take_branch |=> (pc_q == $past(pc_plus4)));

  // R7: a taken branch lands on the target in the very next cycle
  assert_branch_land_R7: assert property (@(posedge clk) disable iff (!rst_n)
    take_branch |=> (pc_q == $past(br_target)));

  // R9: an unknown encoding strobes nothing
  assert_illegal_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.illegal |-> (!rf_wr_en && !dmem_we));

  // R6: only the store opcode reaches the memory strobe
  assert_store_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_we |-> (f_op == OPC_SW));

  // R4: the logical immediate carries no sign
  assert_ori_zext_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (f_op == OPC_ORI) |-> (imm_ext[31:16] == 16'h0000));

  // R10: memory and branch offsets carry their sign
  assert_offset_sext_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((f_op == OPC_LW || f_op == OPC_SW || f_op == OPC_BEQ) && f_imm[15])
      |-> (imm_ext[31:16] == 16'hFFFF));

endmodule

// File: tb/onecyc_core_test.sv
`timescale 1ns/1ps
module onecyc_core_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we;

  always #2.5 clk = ~clk;

  onecyc_core uut (
    .clk(clk), .rst_n(rst_n),
    .imem_addr(imem_addr), .imem_data(imem_data),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata),
    .dmem_we(dmem_we), .dmem_rdata(dmem_rdata)
  );

  logic [31:0] imem [64];
  logic [31:0] dmem [64];
  assign imem_data  = imem[imem_addr[7:2]];
  assign dmem_rdata = dmem[dmem_addr[7:2]];
  always @(posedge clk) if (rst_n && dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;

  // reference model state
  logic [31:0] mreg [32];
  logic [31:0] mmem [64];
  logic [31:0] mpc;
  string       pc_tag;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd, input logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  task automatic mwrite(input logic [4:0] idx, input logic [31:0] v);
    if (idx != 5'd0) mreg[idx] = v;
  endtask

  // checks outputs for the current model instruction, then executes it
  task automatic model_cycle();
    logic [31:0] ins, a, b, sx, zx, ea, npc;
    logic [5:0]  op, fn;
    ins = imem[mpc[7:2]];
    op = ins[31:26]; fn = ins[5:0];
    a  = mreg[ins[25:21]]; b = mreg[ins[20:16]];
    sx = {{16{ins[15]}}, ins[15:0]};
    zx = {16'h0, ins[15:0]};
    ea = a + sx;
    npc = mpc + 32'd4;
    chk(pc_tag, "pc", imem_addr, mpc);
    if (op == 6'h2B) begin
      chk("R6", "store strobe", {31'd0, dmem_we}, 32'd1);
      chk("R6", "store address", dmem_addr, ea);
      chk("R6", "store data", dmem_wdata, b);
    end else begin
      chk((op == 6'h00 || op == 6'h0D || op == 6'h23 || op == 6'h04) ? "R6" : "R9",
          "no store strobe", {31'd0, dmem_we}, 32'd0);
    end
    if (op == 6'h23) chk("R5", "load address", dmem_addr, ea);
    pc_tag = "R2";
    case (op)
      6'h00: case (fn)
        6'h20: mwrite(ins[15:11], a + b);
        6'h22: mwrite(ins[15:11], a - b);
        6'h24: mwrite(ins[15:11], a & b);
        6'h25: mwrite(ins[15:11], a | b);
        default: pc_tag = "R9";
      endcase
      6'h0D: mwrite(ins[20:16], a | zx);
      6'h23: mwrite(ins[20:16], mmem[ea[7:2]]);
      6'h2B: mmem[ea[7:2]] = b;
      6'h04: begin
        pc_tag = "R7";
        if (a == b) npc = npc + {sx[29:0], 2'b00};
      end
      default: pc_tag = "R9";
    endcase
    mpc = npc;
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin
      imem[i] = enc_i(6'h04, 0, 0, 16'hFFFF);
      dmem[i] = 32'hA5A5_0000 | i;
      mmem[i] = 32'hA5A5_0000 | i;
    end
    for (int i = 0; i < 32; i++) mreg[i] = 32'd0;
    imem[0]  = enc_i(6'h0D, 0, 1, 16'h0007);
    imem[1]  = enc_i(6'h0D, 0, 2, 16'h8000);
    imem[2]  = enc_i(6'h0D, 0, 9, 16'h0009);
    imem[3]  = enc_i(6'h0D, 0, 10, 16'h000A);
    imem[4]  = enc_i(6'h0D, 0, 11, 16'h0040);
    imem[5]  = enc_r(1, 2, 3, 6'h20);
    imem[6]  = enc_r(1, 2, 4, 6'h22);
    imem[7]  = enc_r(3, 1, 5, 6'h24);
    imem[8]  = enc_r(4, 1, 6, 6'h25);
    imem[9]  = 32'h012A4020;
    imem[10] = enc_i(6'h0D, 0, 0, 16'h1234);
    imem[11] = enc_i(6'h2B, 11, 3, 16'h0000);
    imem[12] = enc_i(6'h2B, 11, 4, 16'hFFFC);
    imem[13] = enc_i(6'h23, 11, 12, 16'hFFFC);
    imem[14] = enc_r(12, 8, 13, 6'h20);
    imem[15] = enc_i(6'h2B, 11, 13, 16'h0004);
    imem[16] = enc_i(6'h04, 1, 5, 16'h0001);
    imem[17] = enc_i(6'h0D, 0, 14, 16'h0BAD);
    imem[18] = enc_i(6'h04, 1, 2, 16'h0001);
    imem[19] = enc_i(6'h0D, 0, 18, 16'h0055);
    imem[20] = enc_i(6'h0D, 0, 15, 16'h0003);
    imem[21] = enc_i(6'h0D, 0, 16, 16'h0001);
    imem[22] = enc_r(15, 16, 15, 6'h22);
    imem[23] = enc_i(6'h04, 15, 0, 16'h0001);
    imem[24] = enc_i(6'h04, 0, 0, 16'hFFFD);
    imem[25] = enc_i(6'h3F, 1, 17, 16'h0001);
    imem[26] = enc_r(1, 1, 17, 6'h3F);
    imem[27] = enc_i(6'h2B, 11, 0, 16'h0008);
    imem[28] = enc_i(6'h2B, 11, 14, 16'h000C);
    imem[29] = enc_i(6'h2B, 11, 17, 16'h0010);
    imem[30] = enc_i(6'h2B, 11, 8, 16'h0014);
    imem[31] = enc_i(6'h2B, 11, 18, 16'h0018);
    imem[32] = enc_i(6'h2B, 11, 15, 16'h001C);
    imem[33] = enc_i(6'h04, 0, 0, 16'hFFFF);
    mpc = 32'd0;
    pc_tag = "R1";

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "pc in reset", imem_addr, 32'd0);
    chk("R1", "store strobe in reset", {31'd0, dmem_we}, 32'd0);
    rst_n = 1'b1;
    for (int c = 0; c < 80; c++) begin
      model_cycle();
      @(negedge clk);
    end

    chk("R3", "ADD result stored", dmem[16], 32'h0000_8007);
    chk("R10", "store below base / SUB", dmem[15], 32'hFFFF_8007);
    chk("R5", "load used at once", dmem[17], 32'hFFFF_801A);
    chk("R8", "register 0 after write", dmem[18], 32'd0);
    chk("R7", "skipped instruction left no trace", dmem[19], 32'd0);
    chk("R9", "undefined encodings wrote nothing", dmem[20], 32'd0);
    chk("R3", "word 012A4020 gave 9+10", dmem[21], 32'd19);
    chk("R7", "not-taken fall-through ran", dmem[22], 32'h55);
    chk("R10", "backward loop counted down", dmem[23], 32'd0);
    chk("R7", "self loop holds pc", imem_addr, 32'h84);
    chk("R4", "untouched word", dmem[24], 32'hA5A5_0018);
    for (int i = 0; i < 64; i++) chk("R6", "memory image", dmem[i], mmem[i]);
    report();
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog run did not complete actual=%h expected=%h", 32'd0, 32'd1);
      report();
    end
  end

endmodule